// File: doc/BRIEF.md
# Alternating Read/Write Request Arbiter

This block merges two address-request streams, one carrying writes and one carrying reads, into one shared in-order request queue. Each stream uses a valid/ready handshake like a memory-bus address channel. At most one request is accepted per clock. When both streams present a request in the same cycle, the winner is the type that was not accepted most recently, so a steady stream of one type cannot starve the other.

Each accepted request becomes one queue entry. The entry records the request type and its address, transaction tag, burst length and burst kind. A downstream consumer sees the oldest entry at the head output and removes it with a pop strobe. The queue reports empty, full and an occupancy count. A push into a full queue is not possible, and a pop from an empty queue is ignored. The whole block runs on a single clock.

Top module: `rw_req_arbiter`

## Requirements
- R1: When only one stream is valid and the queue is not full, that stream's ready is high in the same cycle and its request is stored at the next clock edge.
- R2: When both streams are valid and the queue is not full, ready goes to the type opposite to the most recently accepted request. After reset, "most recently accepted" counts as read, so the first contested cycle grants the write.
- R3: The two ready outputs are never high in the same cycle, so at most one request enters the queue per clock.
- R4: Each entry is 43 bits wide, laid out as {type[42], address[41:10], tag[9:6], length[5:2], burst kind[1:0]}. The type bit is 1 for a write and 0 for a read.
- R5: The queue holds 8 entries in arrival order. While the queue is not empty, the head output shows the oldest entry, and a pop moves the head to the next entry.
- R6: While the queue is full, both ready outputs are low, and the count and stored contents do not change unless a pop occurs.
- R7: A pop while the queue is empty is ignored: the count stays 0 and empty stays high.
- R8: After reset the count is 0, empty is high and full is low. Empty is high exactly when the count is 0, and full is high exactly when the count is 8.
- R9: An accepted push and a valid pop in the same cycle leave the count unchanged and keep the entries in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write request accepted this cycle |
| wr_addr | input | 32 | Write start address |
| wr_tag | input | 4 | Write transaction tag |
| wr_len | input | 4 | Write burst length |
| wr_kind | input | 2 | Write burst kind |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read request accepted this cycle |
| rd_addr | input | 32 | Read start address |
| rd_tag | input | 4 | Read transaction tag |
| rd_len | input | 4 | Read burst length |
| rd_kind | input | 2 | Read burst kind |
| q_pop | input | 1 | Consumer removes the head entry |
| q_head | output | 43 | Oldest queued entry |
| q_empty | output | 1 | Queue holds no entries |
| q_full | output | 1 | Queue holds 8 entries |
| q_count | output | 4 | Number of queued entries |

## Verification
The in-module assertions check on every cycle that the two readies are never high together and are both low when the queue is full. They also check that the count never exceeds the depth, that an unmatched pop on an empty queue leaves it empty, and that a contested cycle after an accepted write goes to the read. Only the bench's sweeps can show that entries come out in arrival order with every field in its bit position, that the fairness order stays correct across long mixed traffic, and that a simultaneous push and pop keeps the occupancy. The bench does this by comparing every head value, ready and count against its own queue model.

// File: rtl/rw_req_arbiter.sv
module rw_req_arbiter #(
  parameter int ADDR_W  = 32,
  parameter int TAG_W   = 4,
  parameter int LEN_W   = 4,
  parameter int KIND_W  = 2,
  parameter int DEPTH   = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_valid,
  output logic                                   wr_ready,
  input  logic [ADDR_W-1:0]                      wr_addr,
  input  logic [TAG_W-1:0]                       wr_tag,
  input  logic [LEN_W-1:0]                       wr_len,
  input  logic [KIND_W-1:0]                      wr_kind,
  input  logic                                   rd_valid,
  output logic                                   rd_ready,
  input  logic [ADDR_W-1:0]                      rd_addr,
  input  logic [TAG_W-1:0]                       rd_tag,
  input  logic [LEN_W-1:0]                       rd_len,
  input  logic [KIND_W-1:0]                      rd_kind,
  input  logic                                   q_pop,
  output logic [ADDR_W+TAG_W+LEN_W+KIND_W:0]     q_head,
  output logic                                   q_empty,
  output logic                                   q_full,
  output logic [$clog2(DEPTH):0]                 q_count
);
  localparam int ENT_W = 1 + ADDR_W + TAG_W + LEN_W + KIND_W;
  localparam int PTR_W = $clog2(DEPTH);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W:0]   wptr, rptr;
  logic             last_rd;
  logic             pick_wr, push, pop_ok;
  logic [ENT_W-1:0] din;

  assign q_count = wptr - rptr;
  assign q_empty = (wptr == rptr);
  assign q_full  = (q_count == (PTR_W+1)'(DEPTH));

  assign pick_wr  = wr_valid && (!rd_valid || last_rd);
  assign wr_ready = pick_wr && !q_full;
  assign rd_ready = rd_valid && !pick_wr && !q_full;
  assign push     = wr_ready || rd_ready;
  assign pop_ok   = q_pop && !q_empty;

  assign din = wr_ready ? {1'b1, wr_addr, wr_tag, wr_len, wr_kind}
                        : {1'b0, rd_addr, rd_tag, rd_len, rd_kind};
  assign q_head = mem[rptr[PTR_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      last_rd <= 1'b1;
    end else begin
      if (push) begin
        wptr    <= wptr + 1'b1;
        last_rd <= rd_ready;
      end
      if (pop_ok) rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (push) mem[wptr[PTR_W-1:0]] <= din;

  // R3
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ready && rd_ready));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> (!wr_ready && !rd_ready));

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= (PTR_W+1)'(DEPTH));

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop && q_empty && !wr_ready && !rd_ready) |=> q_empty);

  // R2
  alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && rd_valid && !q_full && $past(rst_n) && $past(wr_valid && wr_ready))
      |-> rd_ready);
endmodule

// File: tb/rw_req_arbiter_test.sv
module rw_req_arbiter_test;
  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, rd_valid = 0, q_pop = 0;
  logic [31:0] wr_addr = 0, rd_addr = 0;
  logic [3:0]  wr_tag = 0, rd_tag = 0, wr_len = 0, rd_len = 0;
  logic [1:0]  wr_kind = 0, rd_kind = 0;
  logic wr_ready, rd_ready, q_empty, q_full;
  logic [42:0] q_head;
  logic [3:0]  q_count;

  int checks = 0, failures = 0;
  logic [42:0] mq[$];
  logic last_rd = 1;
  int seq = 0;

  always #2 clk = ~clk;

  rw_req_arbiter uut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic wv, input logic rv, input logic pop);
    logic full, ew, er;
    logic [42:0] went, rent;
    @(negedge clk);
    seq++;
    wr_valid = wv; rd_valid = rv; q_pop = pop;
    wr_addr = 32'hA500_0000 + seq * 7; wr_tag = 4'(seq);     wr_len = 4'(seq * 3); wr_kind = 2'(seq);
    rd_addr = 32'h5A00_0000 + seq * 5; rd_tag = 4'(seq + 9); rd_len = 4'(seq * 5); rd_kind = 2'(seq + 1);
    #1;
    full = (mq.size() == 8);
    ew = wv && !full && (!rv || last_rd);
    er = rv && !full && (!wv || !last_rd);
    if (wv && rv) begin
      chk("R2 contested wr_ready", 64'(wr_ready), 64'(ew));
      chk("R2 contested rd_ready", 64'(rd_ready), 64'(er));
    end else begin
      chk("R1 lone wr_ready", 64'(wr_ready), 64'(ew));
      chk("R1 lone rd_ready", 64'(rd_ready), 64'(er));
    end
    chk("R3 single grant", 64'(wr_ready && rd_ready), 64'(0));
    if (full) chk("R6 full blocks", 64'({wr_ready, rd_ready}), 64'(0));
    chk("R8 count", 64'(q_count), 64'(mq.size()));
    chk("R8 empty", 64'(q_empty), 64'(mq.size() == 0));
    chk("R8 full", 64'(q_full), 64'(full));
    if (mq.size() != 0) begin
      chk("R5 head order", 64'(q_head), 64'(mq[0]));
      chk("R4 type bit", 64'(q_head[42]), 64'(mq[0][42]));
      chk("R4 address field", 64'(q_head[41:10]), 64'(mq[0][41:10]));
    end
    went = {1'b1, wr_addr, wr_tag, wr_len, wr_kind};
    rent = {1'b0, rd_addr, rd_tag, rd_len, rd_kind};
    if (pop && mq.size() != 0) void'(mq.pop_front());
    if (ew) begin mq.push_back(went); last_rd = 0; end
    if (er) begin mq.push_back(rent); last_rd = 1; end
    if (pop && (ew || er) && !full) begin
      @(negedge clk);
      wr_valid = 0; rd_valid = 0; q_pop = 0;
      #1 chk("R9 push with pop count", 64'(q_count), 64'(mq.size()));
    end
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset count", 64'(q_count), 64'(0));
    chk("R8 reset empty", 64'(q_empty), 64'(1));
    chk("R8 reset full", 64'(q_full), 64'(0));
    rst_n = 1;
    // R7: pops on an empty queue
    for (int i = 0; i < 3; i++) step(0, 0, 1);
    chk("R7 empty pop count", 64'(q_count), 64'(0));
    chk("R7 empty pop flag", 64'(q_empty), 64'(1));
    // R2: first contest after reset goes to write
    step(1, 1, 0);
    chk("R2 first contest wrote", 64'(mq[mq.size()-1][42]), 64'(1));
    // fill past full with every request pattern (R6)
    for (int i = 0; i < 24; i++) step(i[0] | i[2], i[1] | i[3], 0);
    // drain
    for (int i = 0; i < 12; i++) step(0, 0, 1);
    // near-exhaustive mixed sweep over valid and pop patterns
    for (int i = 0; i < 2048; i++)
      step(i[0] | i[4], i[1] | i[5], (i[2] & i[3]) | i[6] | (i[7] & i[8]));
    for (int i = 0; i < 10; i++) step(0, 0, 1);
    chk("R5 drained", 64'(q_empty), 64'(1));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule